// File: doc/BRIEF.md
# USB Transceiver Parallel Data-Bus Controller

This block sits on the transceiver side of the parallel link between a USB 2.0 serial interface engine and the line logic. It owns one shared 16-bit data bus and a one-bit upper-byte qualifier. Both can be driven by the engine when it transmits, or by this block when it hands a received word back. The direction follows two handshakes: transmit-valid from the engine and receive-valid from this block. Pad tri-state buffers are built from the separate in, out and per-lane output-enable ports.

Two bus widths are supported. In the two-lane mode, whole 16-bit words cross in both directions and the qualifier tells whether the upper byte is meaningful. In the one-lane mode, transmit bytes arrive on the low lane and received bytes leave on the high lane. Toward the line, the block exposes a byte-wide pull port for transmit bytes, a byte-wide push port for received bytes, and one-cycle start and end requests that the line logic turns into SYNC and end-of-packet.

The width selection only takes effect while the interface is quiet. Transmit words are serialised low byte first.

Top module: `usb_pbus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_ready, rx_valid, rx_active, rx_error, ser_tx_vld, ser_sync_req, ser_eop_req, pbus_oe and hiq_oe are all low.
- R2: Whenever tx_valid is 1, the block drives no bus lane and does not drive the qualifier (pbus_oe = 2'b00, hiq_oe = 0), whatever rx_valid is.
- R3: When tx_valid and rx_valid are both 0, pbus_oe = 2'b00 and hiq_oe = 0.
- R4: In two-lane mode (mode_wide_req = 1 when last sampled), two consecutive received bytes form one word. The first byte is on pbus_out[7:0] and the second on pbus_out[15:8]. hiq_out = 1. While rx_valid = 1 and tx_valid = 0, both lanes and the qualifier are driven. rx_valid rises in the cycle after the second byte is pushed.
- R5: In two-lane mode, a packet with an odd byte count ends with a word whose pbus_out[7:0] holds the last byte, with pbus_out[15:8] = 0 and hiq_out = 0. It is presented in the cycle after that byte is pushed.
- R6: In one-lane mode (mode_wide_req = 0 when last sampled), every received byte is presented alone on pbus_out[15:8] with rx_valid in the following cycle. pbus_oe = 2'b10 and hiq_oe = 0.
- R7: tx_ready is 1 exactly when tx_valid is 1 and the transmit holding register is empty. A rising edge with tx_ready = 1 loads the register, so tx_ready drops and ser_tx_vld rises. The register empties at the edge where its last byte is taken through ser_tx_take.
- R8: In two-lane mode, a loaded word with hiq_in = 1 is offered as pbus_in[7:0] and then pbus_in[15:8]. With hiq_in = 0 only pbus_in[7:0] is offered.
- R9: In one-lane mode, only pbus_in[7:0] is offered as a single byte. hiq_in and pbus_in[15:8] have no effect.
- R10: ser_sync_req is a one-cycle pulse in the cycle after tx_valid rises. ser_eop_req is a one-cycle pulse in the cycle after tx_valid falls.
- R11: rx_active rises in the cycle after ser_rx_sop. It stays high through the cycle in which the packet's final word has rx_valid, and falls in the next cycle.
- R12: rx_error is 1 in the cycle after a byte pushed with ser_rx_err = 1, and is 0 in the cycle after a push without it. It is registered at the same stage as the received data.
- R13: The width mode is resampled only when tx_valid, rx_valid and rx_active are low and the transmit register is empty. A change requested during a packet takes effect after the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide_req | input | 1 | 1 requests two-lane mode, 0 one-lane mode |
| tx_valid | input | 1 | Engine has transmit data on the bus |
| tx_ready | output | 1 | Holding register accepts the bus word at this edge |
| pbus_in | input | 16 | Bus value seen at the pads |
| pbus_out | output | 16 | Value the block drives onto the bus |
| pbus_oe | output | 2 | Output enable per byte lane (bit 1 = upper lane) |
| hiq_in | input | 1 | Upper-byte qualifier seen at the pad |
| hiq_out | output | 1 | Upper-byte qualifier driven by the block |
| hiq_oe | output | 1 | Output enable of the qualifier |
| rx_valid | output | 1 | Received word is on the bus this cycle |
| rx_active | output | 1 | A receive packet is in progress |
| rx_error | output | 1 | Receive error, aligned with the data stage |
| ser_tx_byte | output | 8 | Transmit byte offered to the line side |
| ser_tx_vld | output | 1 | ser_tx_byte holds a byte |
| ser_tx_take | input | 1 | Line side takes the offered byte at this edge |
| ser_sync_req | output | 1 | Request to start a packet with SYNC |
| ser_eop_req | output | 1 | Request to close the packet with end-of-packet |
| ser_rx_sop | input | 1 | Start of a receive packet detected |
| ser_rx_push | input | 1 | A received byte is on ser_rx_byte |
| ser_rx_byte | input | 8 | Received byte |
| ser_rx_last | input | 1 | Pushed byte is the last one of the packet |
| ser_rx_err | input | 1 | Pushed byte was received with an error |

## Verification
A wrong lane pointer or a stale pairing flag in the receive assembler shows up at the next rx_valid pulse, one cycle after the push. It appears as swapped lanes, a wrong qualifier, or a word presented one byte early or late. A stuck holding-register flag in the transmit path shows in the same cycle as a tx_ready that never returns, or as a byte count on the pull port that differs from the qualifier. A mode register that updates mid-packet is caught by the lane enables of the next received word. Bus contention is visible combinationally on the enable ports as soon as tx_valid changes.

// File: rtl/usb_pbus_pkg.sv
package usb_pbus_pkg;

   typedef enum logic {
      LANES_ONE = 1'b0,
      LANES_TWO = 1'b1
   } width_mode_e;

endpackage

// File: rtl/usb_pbus_tx.sv
module usb_pbus_tx
   import usb_pbus_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int BUS_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  width_mode_e       mode,
   input  logic              tx_valid,
   input  logic [BUS_W-1:0]  bus_in,
   input  logic              hiq_in,
   input  logic              take,
   output logic              tx_ready,
   output logic [LANE_W-1:0] out_byte,
   output logic              out_vld,
   output logic              sync_req,
   output logic              eop_req,
   output logic              busy
);

   logic [BUS_W-1:0] hold_q;
   logic             full_q;
   logic             pair_q;
   logic             upper_q;
   logic             txv_q;

   assign tx_ready = tx_valid && !full_q;
   assign out_vld  = full_q;
   assign busy     = full_q;
   assign out_byte = upper_q ? hold_q[BUS_W-1:LANE_W] : hold_q[LANE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q   <= '0;
         full_q   <= 1'b0;
         pair_q   <= 1'b0;
         upper_q  <= 1'b0;
         txv_q    <= 1'b0;
         sync_req <= 1'b0;
         eop_req  <= 1'b0;
      end else begin
         txv_q    <= tx_valid;
         sync_req <= tx_valid && !txv_q;
         eop_req  <= !tx_valid && txv_q;
         if (tx_ready) begin
            hold_q  <= bus_in;
            pair_q  <= (mode == LANES_TWO) && hiq_in;
            upper_q <= 1'b0;
            full_q  <= 1'b1;
         end else if (full_q && take) begin
            if (pair_q && !upper_q) begin
               upper_q <= 1'b1;
            end else begin
               upper_q <= 1'b0;
               full_q  <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/usb_pbus_rx.sv
module usb_pbus_rx
   import usb_pbus_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int BUS_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  width_mode_e       mode,
   input  logic              sop,
   input  logic              push,
   input  logic [LANE_W-1:0] in_byte,
   input  logic              last,
   input  logic              err,
   output logic [BUS_W-1:0]  word,
   output logic              hiq,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_error
);

   logic [LANE_W-1:0] low_q;
   logic              have_low_q;
   logic              final_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q      <= '0;
         have_low_q <= 1'b0;
         final_q    <= 1'b0;
         word       <= '0;
         hiq        <= 1'b0;
         rx_valid   <= 1'b0;
         rx_active  <= 1'b0;
         rx_error   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_error <= push && err;
         if (sop) begin
            rx_active <= 1'b1;
         end else if (rx_valid && final_q) begin
            rx_active <= 1'b0;
         end
         if (push) begin
            if (mode == LANES_TWO) begin
               if (have_low_q) begin
                  word       <= {in_byte, low_q};
                  hiq        <= 1'b1;
                  rx_valid   <= 1'b1;
                  final_q    <= last;
                  have_low_q <= 1'b0;
               end else if (last) begin
                  word     <= {{LANE_W{1'b0}}, in_byte};
                  hiq      <= 1'b0;
                  rx_valid <= 1'b1;
                  final_q  <= 1'b1;
               end else begin
                  low_q      <= in_byte;
                  have_low_q <= 1'b1;
               end
            end else begin
               word     <= {in_byte, {LANE_W{1'b0}}};
               hiq      <= 1'b0;
               rx_valid <= 1'b1;
               final_q  <= last;
            end
         end
      end
   end

endmodule

// File: rtl/usb_pbus_dir.sv
module usb_pbus_dir
   import usb_pbus_pkg::*;
#(
   parameter int          LANE_W   = 8,
   parameter width_mode_e RST_MODE = LANES_TWO,
   localparam int         BUS_W    = 2 * LANE_W,
   localparam int         N_LANES  = BUS_W / LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_req,
   input  logic               tx_valid,
   input  logic               rx_valid,
   input  logic               rx_active,
   input  logic               tx_busy,
   output width_mode_e        mode,
   output logic [N_LANES-1:0] lane_oe,
   output logic               hiq_oe
);

   logic quiet;
   logic drive;

   assign quiet = !tx_valid && !rx_valid && !rx_active && !tx_busy;
   assign drive = !tx_valid && rx_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= RST_MODE;
      end else if (quiet) begin
         mode <= width_mode_e'(mode_req);
      end
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      if (g == N_LANES - 1) begin : g_top
         assign lane_oe[g] = drive;
      end else begin : g_low
         assign lane_oe[g] = drive && (mode == LANES_TWO);
      end
   end

   assign hiq_oe = drive && (mode == LANES_TWO);

endmodule

// File: rtl/usb_pbus_ctrl.sv
module usb_pbus_ctrl
   import usb_pbus_pkg::*;
#(
   parameter int          LANE_W   = 8,
   parameter width_mode_e RST_MODE = LANES_TWO,
   localparam int         BUS_W    = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wide_req,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [BUS_W-1:0]  pbus_in,
   output logic [BUS_W-1:0]  pbus_out,
   output logic [1:0]        pbus_oe,
   input  logic              hiq_in,
   output logic              hiq_out,
   output logic              hiq_oe,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_error,
   output logic [LANE_W-1:0] ser_tx_byte,
   output logic              ser_tx_vld,
   input  logic              ser_tx_take,
   output logic              ser_sync_req,
   output logic              ser_eop_req,
   input  logic              ser_rx_sop,
   input  logic              ser_rx_push,
   input  logic [LANE_W-1:0] ser_rx_byte,
   input  logic              ser_rx_last,
   input  logic              ser_rx_err
);

   if (LANE_W < 2) begin : g_lane_w_chk
      $error("usb_pbus_ctrl: LANE_W must be at least 2");
   end

   width_mode_e mode_w;
   logic        tx_busy;

   usb_pbus_dir #(.LANE_W(LANE_W), .RST_MODE(RST_MODE)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_req  (mode_wide_req),
      .tx_valid  (tx_valid),
      .rx_valid  (rx_valid),
      .rx_active (rx_active),
      .tx_busy   (tx_busy),
      .mode      (mode_w),
      .lane_oe   (pbus_oe),
      .hiq_oe    (hiq_oe)
   );

   usb_pbus_tx #(.LANE_W(LANE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_w),
      .tx_valid (tx_valid),
      .bus_in   (pbus_in),
      .hiq_in   (hiq_in),
      .take     (ser_tx_take),
      .tx_ready (tx_ready),
      .out_byte (ser_tx_byte),
      .out_vld  (ser_tx_vld),
      .sync_req (ser_sync_req),
      .eop_req  (ser_eop_req),
      .busy     (tx_busy)
   );

   usb_pbus_rx #(.LANE_W(LANE_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_w),
      .sop       (ser_rx_sop),
      .push      (ser_rx_push),
      .in_byte   (ser_rx_byte),
      .last      (ser_rx_last),
      .err       (ser_rx_err),
      .word      (pbus_out),
      .hiq       (hiq_out),
      .rx_valid  (rx_valid),
      .rx_active (rx_active),
      .rx_error  (rx_error)
   );

endmodule

// File: rtl/usb_pbus_chk.sv
module usb_pbus_chk
   import usb_pbus_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic        rx_valid,
   input logic        rx_active,
   input logic [1:0]  pbus_oe,
   input logic        hiq_oe,
   input logic        ser_sync_req,
   input logic        ser_eop_req,
   input width_mode_e mode
);

   // R2
   tx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (pbus_oe == 2'b00 && !hiq_oe));

   // R3
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && !rx_valid) |-> (pbus_oe == 2'b00 && !hiq_oe));

   // R6
   rx_upper_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_valid && rx_valid) |-> pbus_oe[1]);

   // R7
   ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> tx_valid);

   // R10
   sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |=> ser_sync_req);

   // R10
   eop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_valid) |=> ser_eop_req);

   // R10
   sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sync_req |=> !ser_sync_req);

   // R11
   valid_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);

   // R13
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid || rx_valid || rx_active) |=> $stable(mode));

endmodule

bind usb_pbus_ctrl usb_pbus_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .rx_valid     (rx_valid),
   .rx_active    (rx_active),
   .pbus_oe      (pbus_oe),
   .hiq_oe       (hiq_oe),
   .ser_sync_req (ser_sync_req),
   .ser_eop_req  (ser_eop_req),
   .mode         (mode_w)
);

// File: tb/tb_usb_pbus_ctrl.sv
`timescale 1ns/1ps
module tb_usb_pbus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wide_req = 1'b1;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [15:0] pbus_in = '0;
   logic [15:0] pbus_out;
   logic [1:0]  pbus_oe;
   logic        hiq_in = 1'b0;
   logic        hiq_out;
   logic        hiq_oe;
   logic        rx_valid;
   logic        rx_active;
   logic        rx_error;
   logic [7:0]  ser_tx_byte;
   logic        ser_tx_vld;
   logic        ser_tx_take = 1'b0;
   logic        ser_sync_req;
   logic        ser_eop_req;
   logic        ser_rx_sop = 1'b0;
   logic        ser_rx_push = 1'b0;
   logic [7:0]  ser_rx_byte = '0;
   logic        ser_rx_last = 1'b0;
   logic        ser_rx_err = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   usb_pbus_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mode_wide_req(mode_wide_req),
      .tx_valid(tx_valid), .tx_ready(tx_ready),
      .pbus_in(pbus_in), .pbus_out(pbus_out), .pbus_oe(pbus_oe),
      .hiq_in(hiq_in), .hiq_out(hiq_out), .hiq_oe(hiq_oe),
      .rx_valid(rx_valid), .rx_active(rx_active), .rx_error(rx_error),
      .ser_tx_byte(ser_tx_byte), .ser_tx_vld(ser_tx_vld), .ser_tx_take(ser_tx_take),
      .ser_sync_req(ser_sync_req), .ser_eop_req(ser_eop_req),
      .ser_rx_sop(ser_rx_sop), .ser_rx_push(ser_rx_push), .ser_rx_byte(ser_rx_byte),
      .ser_rx_last(ser_rx_last), .ser_rx_err(ser_rx_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Called at a falling edge; returns at a falling edge with tx_ready free.
   task automatic tx_word(input logic [15:0] w, input logic h, input bit wide, input bit first);
      bit two = wide && h;
      tx_valid = 1'b1; pbus_in = w; hiq_in = h;
      #1;
      chk("R7", "ready when empty", 32'(tx_ready), 32'd1);
      chk("R2", "no drive while tx", {29'd0, pbus_oe, hiq_oe}, 32'd0);
      @(negedge clk);
      chk("R7", "ready after load", 32'(tx_ready), 32'd0);
      chk("R7", "byte offered", 32'(ser_tx_vld), 32'd1);
      chk(wide ? "R8" : "R9", "first byte", 32'(ser_tx_byte), 32'(w[7:0]));
      chk("R10", "sync pulse", 32'(ser_sync_req), 32'(first));
      ser_tx_take = 1'b1;
      if (two) begin
         @(negedge clk);
         chk("R8", "second byte valid", 32'(ser_tx_vld), 32'd1);
         chk("R8", "second byte", 32'(ser_tx_byte), 32'(w[15:8]));
      end
      @(negedge clk);
      ser_tx_take = 1'b0;
      chk(wide ? "R8" : "R9", "register empty", 32'(ser_tx_vld), 32'd0);
      #1;
      chk("R7", "ready again", 32'(tx_ready), 32'd1);
   endtask

   task automatic rx_push(input logic [7:0] b, input logic last, input logic err);
      ser_rx_push = 1'b1; ser_rx_byte = b; ser_rx_last = last; ser_rx_err = err;
      @(negedge clk);
      ser_rx_push = 1'b0; ser_rx_last = 1'b0; ser_rx_err = 1'b0;
   endtask

   task automatic rx_start();
      ser_rx_sop = 1'b1;
      @(negedge clk);
      ser_rx_sop = 1'b0;
      chk("R11", "active after sop", 32'(rx_active), 32'd1);
   endtask

   task automatic rx_packet_wide(input int n, input int seed);
      logic [7:0] prev = '0;
      rx_start();
      for (int k = 0; k < n; k++) begin
         logic [7:0] b = 8'(seed * 37 + k * 11 + 5);
         bit last = (k == n - 1);
         rx_push(b, last, 1'b0);
         chk("R11", "active during packet", 32'(rx_active), 32'd1);
         if (k % 2 == 1) begin
            chk("R4", "pair valid", 32'(rx_valid), 32'd1);
            chk("R4", "pair word", 32'(pbus_out), {16'd0, b, prev});
            chk("R4", "pair qualifier", 32'(hiq_out), 32'd1);
            chk("R4", "pair drive", {29'd0, pbus_oe, hiq_oe}, 32'b111);
         end else if (last) begin
            chk("R5", "odd tail valid", 32'(rx_valid), 32'd1);
            chk("R5", "odd tail word", 32'(pbus_out), {24'd0, b});
            chk("R5", "odd tail qualifier", 32'(hiq_out), 32'd0);
         end else begin
            chk("R4", "no word after first byte", 32'(rx_valid), 32'd0);
            chk("R3", "quiet bus", {29'd0, pbus_oe, hiq_oe}, 32'd0);
         end
         prev = b;
      end
      @(negedge clk);
      chk("R11", "active drops after final word", 32'(rx_active), 32'd0);
      chk("R3", "bus released", {29'd0, pbus_oe, hiq_oe}, 32'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "outputs in reset",
          {23'd0, tx_ready, rx_valid, rx_active, rx_error, ser_tx_vld,
           ser_sync_req, ser_eop_req, pbus_oe != 2'b00, hiq_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset",
          {23'd0, tx_ready, rx_valid, rx_active, rx_error, ser_tx_vld,
           ser_sync_req, ser_eop_req, pbus_oe != 2'b00, hiq_oe}, 32'd0);

      // Two-lane transmit sweep
      for (int i = 0; i < 12; i++) begin
         logic [15:0] w = 16'(i * 16'h1357) ^ 16'hA5C3;
         tx_word(w, 1'(i % 2), 1'b1, i == 0);
      end
      tx_valid = 1'b0;
      @(negedge clk);
      chk("R10", "eop pulse", 32'(ser_eop_req), 32'd1);
      chk("R10", "no sync at end", 32'(ser_sync_req), 32'd0);
      @(negedge clk);
      chk("R10", "eop one cycle", 32'(ser_eop_req), 32'd0);

      // Two-lane receive sweep over packet lengths
      for (int i = 0; i < 10; i++) rx_packet_wide(i % 5 + 1, i);

      // R12 error timing
      rx_start();
      rx_push(8'h3C, 1'b0, 1'b1);
      chk("R12", "error after bad byte", 32'(rx_error), 32'd1);
      chk("R12", "no word yet", 32'(rx_valid), 32'd0);
      rx_push(8'hC3, 1'b1, 1'b0);
      chk("R12", "error clear on good byte", 32'(rx_error), 32'd0);
      chk("R12", "word with data stage", 32'(pbus_out), 32'hC33C);
      @(negedge clk);

      // Switch to one-lane mode while idle
      mode_wide_req = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         logic [15:0] w = 16'(i * 16'h2F1D) ^ 16'hFF00;
         tx_word(w, 1'b1, 1'b0, i == 0);
      end
      tx_valid = 1'b0;
      repeat (2) @(negedge clk);

      // One-lane receive
      rx_start();
      for (int k = 0; k < 5; k++) begin
         logic [7:0] b = 8'(k * 53 + 9);
         rx_push(b, k == 4, 1'b0);
         chk("R6", "byte valid", 32'(rx_valid), 32'd1);
         chk("R6", "upper lane data", 32'(pbus_out[15:8]), 32'(b));
         chk("R6", "upper lane only", {29'd0, pbus_oe, hiq_oe}, 32'b100);
         if (k == 2) begin
            tx_valid = 1'b1;
            #1;
            chk("R2", "tx overrides rx drive", {29'd0, pbus_oe, hiq_oe}, 32'd0);
            tx_valid = 1'b0;
         end
      end
      @(negedge clk);
      chk("R11", "active drops", 32'(rx_active), 32'd0);
      @(negedge clk);

      // R13 deferred mode change
      rx_start();
      mode_wide_req = 1'b1;
      repeat (2) @(negedge clk);
      rx_push(8'h5A, 1'b1, 1'b0);
      chk("R13", "still one lane", {29'd0, pbus_oe, hiq_oe}, 32'b100);
      chk("R13", "still upper lane", 32'(pbus_out[15:8]), 32'h5A);
      repeat (2) @(negedge clk);
      rx_start();
      rx_push(8'h11, 1'b0, 1'b0);
      rx_push(8'h22, 1'b1, 1'b0);
      chk("R13", "two lanes after idle", {29'd0, pbus_oe, hiq_oe}, 32'b111);
      chk("R13", "word after idle", 32'(pbus_out), 32'h2211);
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule